// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a single-wire serialized interrupt bus. It runs on the bus clock and shares one open-drain line with the peripherals. A cycle opens with a start frame in which the host holds the line low. Interrupt data slots follow, one per interrupt line. A stop frame closes the cycle. Each peripheral pulls the line low in the sample phase of its own slot to report its interrupt as asserted. The host turns the slot levels into a parallel interrupt vector. A separate system-management output is taken from slot 2. Three of the outputs have a programmable output polarity.

A single control register sets the block up. It holds the engine enable, the cycle mode, the number of data slots, the start pulse width and the polarity bits. In continuous mode the host starts every cycle by itself. In quiet mode the line stays idle until a peripheral pulls it low for one clock. The host then takes over and finishes the start frame. The decoded vector is updated only at the end of each cycle. A register write takes effect at the next start frame.

Top module: `sirq_host`

## Requirements
- R1: With enable (register bit 0) at 0, the line is never driven, `irq_o` equals the polarity pattern (bit 0 from bit 8, bit 1 from bit 9, all other bits 0), and `smi_o` equals bit 10. A disable written mid-cycle stops driving from the next clock.
- R2: In continuous mode (bit 1 = 0), after the stop frame the line is released for exactly two clocks (turnaround, idle), and then the next start frame begins.
- R3: The number of data slots is 17 plus register bits 5:2, so the range is 17 to 32. Between the end of the start frame and the beginning of the stop frame the line is released for 1 + 3·N clocks.
- R4: Start frame width from bits 7:6: 0 gives 4 clocks, 1 gives 6 clocks, 2 gives 8 clocks, and 3 falls back to 4 clocks.
- R5: The stop frame lasts 3 clocks when the mode bit is continuous and 2 clocks when it is quiet. The mode bit is read when the stop frame begins.
- R6: In quiet mode (bit 1 = 1) the host never starts a cycle while the line stays high. A one-clock low from a peripheral while idle makes the host drive for the start width minus one clock.
- R7: Each slot takes 3 clocks, and the first slot begins right after the one turnaround clock that follows the start frame. A low in the first clock of slot n sets interrupt n, and a high clears it. Slots at or above N read as not asserted.
- R8: `irq_o[0]`, `irq_o[1]` and `smi_o` (from slot 2) are inverted when their polarity bits (8, 9, 10) are 1. All other `irq_o` bits are active high.
- R9: The decoded outputs change only one clock after the stop turnaround, when the cycle completes (or on disable).
- R10: Register writes that land mid-cycle leave the slot count and start width of that cycle unchanged. They apply from the next start frame.
- R11: After reset the register reads 0, the line is released and all outputs are 0.
- R12: `cfg_rdata` returns the last value written through `cfg_we`/`cfg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Control register write data |
| cfg_rdata | output | CFG_W | Control register contents |
| sirq_oe | output | 1 | Line output enable (drive when 1) |
| sirq_do | output | 1 | Line output value (always low, open drain) |
| sirq_di | input | 1 | Sampled line level |
| irq_o | output | MAX_SLOTS | Decoded interrupt vector |
| smi_o | output | 1 | Decoded system-management interrupt |

## Verification
The bench builds the block with its default parameters: 32 vector bits and a base of 17 slots. With these values the whole slot-count field is reachable, from 17 slots up to the 32-slot case that uses the top vector bit. The peripheral model in the bench reacts to the line. It counts the host's drive and release stretches, so the start width, slot count, stop length and restart gap are measured as the line behaves and not taken from internal state. Patterns with bits above the programmed slot count show that only real slots are decoded.

// File: rtl/sirq_host.sv
module sirq_host #(
  parameter int MAX_SLOTS   = 32,
  parameter int BASE_FRAMES = 17,
  parameter int CFG_W       = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  output logic                 sirq_oe,
  output logic                 sirq_do,
  input  logic                 sirq_di,
  output logic [MAX_SLOTS-1:0] irq_o,
  output logic                 smi_o
);
  localparam int SLOT_W = $clog2(MAX_SLOTS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_STA_TA, S_DATA, S_STOP, S_STP_TA} st_t;

  st_t                  st;
  logic [CFG_W-1:0]     cfg_q;
  logic [2:0]           cnt;
  logic [1:0]           ph;
  logic [SLOT_W-1:0]    slot, last;
  logic [MAX_SLOTS-1:0] shadow, lat;
  logic [2:0]           wid_m1;
  logic                 en_nx;

  assign en_nx = cfg_we ? cfg_wdata[0] : cfg_q[0];

  always_comb
    case (cfg_q[7:6])
      2'd1:    wid_m1 = 3'd5;
      2'd2:    wid_m1 = 3'd7;
      default: wid_m1 = 3'd3;
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cfg_q  <= '0;
      cnt    <= '0;
      ph     <= '0;
      slot   <= '0;
      last   <= '0;
      shadow <= '0;
      lat    <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if (!en_nx) begin
        st  <= S_IDLE;
        lat <= '0;
      end else begin
        case (st)
          S_IDLE:
            if (cfg_q[0] && (!cfg_q[1] || !sirq_di)) begin
              st     <= S_START;
              cnt    <= cfg_q[1] ? wid_m1 - 3'd1 : wid_m1;
              last   <= SLOT_W'(BASE_FRAMES - 1) + SLOT_W'(cfg_q[5:2]);
              shadow <= '0;
            end
          S_START:
            if (cnt == 3'd0) st <= S_STA_TA;
            else cnt <= cnt - 3'd1;
          S_STA_TA: begin
            st   <= S_DATA;
            ph   <= 2'd0;
            slot <= '0;
          end
          S_DATA: begin
            if (ph == 2'd0) shadow[slot] <= !sirq_di;
            if (ph == 2'd2) begin
              ph <= 2'd0;
              if (slot == last) begin
                st  <= S_STOP;
                cnt <= cfg_q[1] ? 3'd1 : 3'd2;
              end else begin
                slot <= slot + 1'b1;
              end
            end else begin
              ph <= ph + 2'd1;
            end
          end
          S_STOP:
            if (cnt == 3'd0) st <= S_STP_TA;
            else cnt <= cnt - 3'd1;
          S_STP_TA: begin
            st  <= S_IDLE;
            lat <= shadow;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign cfg_rdata = cfg_q;
  assign sirq_oe   = (st == S_START) || (st == S_STOP);
  assign sirq_do   = 1'b0;
  assign irq_o     = lat ^ MAX_SLOTS'({cfg_q[9], cfg_q[8]});
  assign smi_o     = lat[2] ^ cfg_q[10];

  a_r1_off_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[0] |-> !sirq_oe);
  a_r1_off_smi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[0] |-> (smi_o == cfg_q[10]));
  a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (slot <= last));
  a_r5_stop_short: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP) |-> (cnt <= 3'd2));
  a_r6_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cfg_q[1] && sirq_di && !cfg_we) |=> (st == S_IDLE));
  a_r9_hold_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_STP_TA && en_nx && cfg_q[0]) |=> $stable(lat));
endmodule

// File: tb/sirq_host_tb.sv
module sirq_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;
  localparam logic [40:0] VEC [6] = '{
    {3'b000, 2'd0, 4'd0,  32'h0000_0005},
    {3'b011, 2'd1, 4'd15, 32'h8000_0003},
    {3'b100, 2'd2, 4'd3,  32'h0012_3404},
    {3'b101, 2'd3, 4'd7,  32'hFFFF_FFFF},
    {3'b010, 2'd0, 4'd14, 32'h4000_0000},
    {3'b000, 2'd2, 4'd1,  32'h0006_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, periph_low = 1'b0;
  logic [10:0] cfg_wdata = '0;
  logic [10:0] cfg_rdata;
  logic sirq_oe, sirq_do, sirq_di, smi_o;
  logic [NS-1:0] irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  assign sirq_di = !((sirq_oe && !sirq_do) || periph_low);
  always #(CLK_PERIOD/2) clk = ~clk;

  sirq_host u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sirq_oe(sirq_oe), .sirq_do(sirq_do),
    .sirq_di(sirq_di), .irq_o(irq_o), .smi_o(smi_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic idle_check(input string tag, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sirq_oe) seen++;
    end
    check(tag, seen, 0);
  endtask

  task automatic run_cycle(input logic [31:0] pat, input bit do_wr, input logic [10:0] wv,
                           output int w, output int nrel, output int stp);
    w = 0; nrel = 0; stp = 0;
    while (!sirq_oe) @(negedge clk);
    while (sirq_oe) begin w++; @(negedge clk); end
    while (!sirq_oe) begin
      periph_low = (nrel >= 1 && (nrel - 1) % 3 == 0) ? pat[((nrel - 1) / 3) % 32] : 1'b0;
      cfg_we = do_wr && nrel == 10;
      if (cfg_we) cfg_wdata = wv;
      nrel++;
      @(negedge clk);
    end
    periph_low = 1'b0;
    cfg_we = 1'b0;
    while (sirq_oe) begin stp++; @(negedge clk); end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    int w, nr, sp, nfr, ew;
    logic [10:0] cv;
    logic [31:0] mask, m, inact;
    logic [2:0] pol;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 cfg_rdata", cfg_rdata, 0);
    check("R11 irq_o", irq_o, 0);
    check("R11 smi_o", smi_o, 0);
    check("R11 line", sirq_oe, 0);
    idle_check("R1 disabled never drives", 20);

    for (int k = 0; k < 6; k++) begin
      pol = VEC[k][40:38];
      cv  = {pol, VEC[k][37:36], VEC[k][35:32], 1'b0, 1'b1};
      wr(11'h0);
      wr(cv);
      check("R12 readback", cfg_rdata, cv);
      ew   = (VEC[k][37:36] == 2'd1) ? 6 : (VEC[k][37:36] == 2'd2) ? 8 : 4;
      nfr  = 17 + int'(VEC[k][35:32]);
      mask = (nfr == 32) ? 32'hFFFF_FFFF : ((32'h1 << nfr) - 32'h1);
      inact = {30'b0, pol[1], pol[0]};
      run_cycle(VEC[k][31:0], 1'b0, 11'h0, w, nr, sp);
      check("R4 start width", w, ew);
      check("R3 released data window", nr, 1 + 3 * nfr);
      check("R5 continuous stop", sp, 3);
      check("R9 vector held until cycle end", irq_o, inact);
      check("R9 smi held until cycle end", smi_o, pol[2]);
      @(negedge clk);
      m = VEC[k][31:0] & mask;
      check("R7 R8 decoded vector", irq_o, m ^ inact);
      check("R8 smi polarity", smi_o, m[2] ^ pol[2]);
      check("R2 idle clock", sirq_oe, 0);
      @(negedge clk);
      check("R2 restart", sirq_oe, 1);
    end

    wr(11'h0);
    wr({3'b101, 2'd0, 4'd0, 1'b0, 1'b1});
    run_cycle(32'h1, 1'b0, 11'h0, w, nr, sp);
    @(negedge clk);
    check("R8 active-low asserted", irq_o, 32'h0);
    while (!sirq_oe) @(negedge clk);
    wr({3'b101, 2'd0, 4'd0, 1'b0, 1'b0});
    check("R1 disable releases line", sirq_oe, 0);
    check("R1 disable inactive vector", irq_o, 32'h1);
    check("R1 disable inactive smi", smi_o, 1);
    idle_check("R1 stays released", 30);

    wr(11'h0);
    wr({3'b000, 2'd0, 4'd0, 1'b0, 1'b1});
    run_cycle(32'h0, 1'b1, {3'b000, 2'd2, 4'd15, 1'b0, 1'b1}, w, nr, sp);
    check("R10 width unchanged mid-cycle", w, 4);
    check("R10 slots unchanged mid-cycle", nr, 52);
    run_cycle(32'h0, 1'b0, 11'h0, w, nr, sp);
    check("R10 new width next cycle", w, 8);
    check("R10 new slots next cycle", nr, 97);

    wr(11'h0);
    wr({3'b001, 2'd2, 4'd0, 1'b1, 1'b1});
    idle_check("R6 quiet waits", 25);
    periph_low = 1'b1;
    @(negedge clk);
    periph_low = 1'b0;
    run_cycle(32'h0000_0002, 1'b0, 11'h0, w, nr, sp);
    check("R6 host share of start", w, 7);
    check("R3 quiet slots", nr, 52);
    check("R5 quiet stop", sp, 2);
    @(negedge clk);
    check("R7 quiet decoded", irq_o, 32'h3);
    idle_check("R6 quiet idle after cycle", 25);

    done = 1;
    summary();
  end
endmodule